// File: doc/BRIEF.md
# Four-Channel SPI Master Transfer Control Core

This block holds the per-channel state of a four-channel SPI master and decides when each channel moves a word. Every channel owns a setup word, a three-flag status word, an enable bit, a transmit holding word and a receive holding word. Software reaches all of them over a simple 32-bit register bus with single-cycle write and read strobes. Read data is registered and appears one cycle after the read strobe.

A bus access that can start traffic arms a one-cycle evaluation pulse for its channel. Three kinds of access do this: a transmit write, a receive read, or turning the enable bit on. In the following cycle the channel checks its direction mode and its flags. If nothing blocks it, the channel completes a transfer. When exchange is allowed, the transmit word is presented on a single-cycle exchange port and the returned word is captured in the same cycle. Each channel also raises a transmit and a receive DMA request from its enable bit, its setup bits and its flags.

Top module: `mspi_xfer_core`

## Requirements
- R1: After reset, every channel reads setup 0x060000, status 2 (transmit-empty only) and enable 0. Its transmit word is 0 and both DMA requests are low.
- R2: Channel c's registers sit at byte address 0x2C + 0x14*c, in this order: setup (+0), status (+4), enable (+8), transmit (+C), receive (+10). A read of any other address returns 0.
- R3: A setup write stores only bits 22:0 of the write data. Bits 13:12 are the direction: 0 is both directions, 1 is receive-only, 2 is transmit-only. Bits 11:7 are the word-length field.
- R4: Writes to the status and receive addresses change nothing.
- R5: A transmit write stores the word, clears transmit-empty (status bit 1), and evaluates a transfer in the next cycle.
- R6: An evaluation does nothing if the channel is disabled. It also does nothing if receive-full (status bit 0) is set while the direction is not transmit-only and setup bit 19 is clear. It also does nothing if transmit-empty is set while the direction is not receive-only.
- R7: A completed transfer clears the transmit word and sets end-of-transfer (status bit 2) and transmit-empty. It sets receive-full unless the direction is transmit-only.
- R8: A completed transfer drives the exchange port only when `xchg_inhibit` is low or setup bit 20 is set. The port carries the transmit word, the channel number and a length of the word-length field plus one, and the returned word becomes the receive word. Otherwise the receive word is kept.
- R9: A receive read returns the stored receive word, clears receive-full and evaluates a transfer in the next cycle.
- R10: An enable write with bit 0 set on a disabled channel enables it and evaluates a transfer. Any other enable write stores bit 0 and starts nothing.
- R11: The transmit DMA request of a channel is high exactly when it is enabled, setup bit 14 is set, transmit-empty is set and the direction is not receive-only.
- R12: The receive DMA request of a channel is high exactly when it is enabled, setup bit 15 is set, receive-full is set and the direction is not transmit-only.
- R13: The exchange port is valid at most once per access, and only in the cycle right after an accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| xchg_inhibit | input | 1 | Suppresses exchange unless setup bit 20 is set |
| sx_valid | output | 1 | Exchange port active this cycle |
| sx_chan | output | 2 | Channel being exchanged |
| sx_len | output | 6 | Word length in bits |
| sx_wdata | output | 32 | Word sent |
| sx_rdata | input | 32 | Word returned, sampled while sx_valid |
| tx_dreq | output | 4 | Transmit DMA request per channel |
| rx_dreq | output | 4 | Receive DMA request per channel |

## Verification
The checker enforces four properties on every cycle. Evaluation pulses and exchanges follow an accepted access by one cycle. At most one channel evaluates at a time. No DMA request is raised by a disabled channel or in a direction its mode excludes. The bench runs a behavioural model in parallel with the design. It sweeps every channel through every legal direction, both bypass and force settings and both inhibit levels. Only this sweep can show how the stall rules, the completion flags and the captured receive words combine over a sequence of accesses.

// File: rtl/mspi_pkg.sv
package mspi_pkg;

    localparam int CFG_W     = 23;
    localparam int LEN_W     = 6;
    localparam int B_WL_LO   = 7;
    localparam int B_DIR_LO  = 12;
    localparam int B_TXDMA   = 14;
    localparam int B_RXDMA   = 15;
    localparam int B_RXBYP   = 19;
    localparam int B_FORCE   = 20;
    localparam logic [CFG_W-1:0] CFG_RST = 23'h06_0000;

    typedef enum logic [1:0] {
        DIR_BOTH   = 2'd0,
        DIR_RXONLY = 2'd1,
        DIR_TXONLY = 2'd2,
        DIR_BAD    = 2'd3
    } dir_e;

    typedef enum logic [2:0] {
        RS_CFG  = 3'd0,
        RS_STAT = 3'd1,
        RS_EN   = 3'd2,
        RS_TX   = 3'd3,
        RS_RX   = 3'd4,
        RS_NONE = 3'd7
    } rsel_e;

    typedef struct packed {
        logic eot;
        logic txe;
        logic rxf;
    } chan_flags_t;

    function automatic logic f_blocked(logic rxf, logic txe, dir_e dir, logic rx_bypass);
        return (rxf && dir != DIR_TXONLY && !rx_bypass) || (txe && dir != DIR_RXONLY);
    endfunction

    function automatic logic [LEN_W-1:0] f_len(logic [4:0] wl);
        return {1'b0, wl} + LEN_W'(1);
    endfunction

endpackage

// File: rtl/mspi_addr_dec.sv
module mspi_addr_dec
    import mspi_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int AW     = 8,
    parameter int BASE   = 'h2C,
    parameter int STRIDE = 'h14,
    localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [CW-1:0] chan,
    output rsel_e         rsel
);
    logic [AW-1:0] off;

    always_comb begin
        hit  = 1'b0;
        chan = '0;
        rsel = RS_NONE;
        off  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr >= AW'(BASE + c * STRIDE) &&
                addr <  AW'(BASE + (c + 1) * STRIDE) &&
                addr[1:0] == 2'b00) begin
                off  = addr - AW'(BASE + c * STRIDE);
                hit  = 1'b1;
                chan = CW'(c);
                rsel = rsel_e'(off[4:2]);
            end
        end
    end
endmodule

// File: rtl/mspi_chan.sv
module mspi_chan
    import mspi_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cfg,
    input  logic             wr_en,
    input  logic             wr_tx,
    input  logic             rd_rx,
    input  logic [DW-1:0]    wdata,
    input  logic             xchg_inhibit,
    input  logic [DW-1:0]    sx_rdata,
    output logic [CFG_W-1:0] cfg,
    output chan_flags_t      flags,
    output logic             en,
    output logic [DW-1:0]    tx,
    output logic [DW-1:0]    rx,
    output logic             eval_o,
    output logic             xchg_go,
    output logic             tx_dreq,
    output logic             rx_dreq
);
    logic eval_q;
    logic complete;
    dir_e dir;

    assign dir      = dir_e'(cfg[B_DIR_LO +: 2]);
    assign complete = eval_q && en && !f_blocked(flags.rxf, flags.txe, dir, cfg[B_RXBYP]);
    assign xchg_go  = complete && (!xchg_inhibit || cfg[B_FORCE]);
    assign eval_o   = eval_q;

    assign tx_dreq = en && cfg[B_TXDMA] && flags.txe && dir != DIR_RXONLY;
    assign rx_dreq = en && cfg[B_RXDMA] && flags.rxf && dir != DIR_TXONLY;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= CFG_RST;
            flags  <= '{eot: 1'b0, txe: 1'b1, rxf: 1'b0};
            en     <= 1'b0;
            tx     <= '0;
            rx     <= '0;
            eval_q <= 1'b0;
        end else begin
            eval_q <= 1'b0;
            if (wr_cfg) cfg <= wdata[CFG_W-1:0];
            if (wr_en) begin
                if (wdata[0] && !en) begin
                    en     <= 1'b1;
                    eval_q <= 1'b1;
                end else begin
                    en <= wdata[0];
                end
            end
            if (wr_tx) begin
                tx        <= wdata;
                flags.txe <= 1'b0;
                eval_q    <= 1'b1;
            end
            if (rd_rx) begin
                flags.rxf <= 1'b0;
                eval_q    <= 1'b1;
            end
            if (complete) begin
                if (xchg_go) rx <= sx_rdata;
                tx        <= '0;
                flags.eot <= 1'b1;
                flags.txe <= 1'b1;
                if (dir != DIR_TXONLY) flags.rxf <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mspi_xfer_core.sv
module mspi_xfer_core
    import mspi_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 32,
    parameter int AW     = 8,
    localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             xchg_inhibit,
    output logic             sx_valid,
    output logic [CW-1:0]    sx_chan,
    output logic [LEN_W-1:0] sx_len,
    output logic [DW-1:0]    sx_wdata,
    input  logic [DW-1:0]    sx_rdata,
    output logic [NCH-1:0]   tx_dreq,
    output logic [NCH-1:0]   rx_dreq
);
    logic          dec_hit;
    logic [CW-1:0] dec_chan;
    rsel_e         dec_rsel;

    logic [CFG_W-1:0] cfg_a   [NCH];
    chan_flags_t      flags_a [NCH];
    logic [DW-1:0]    tx_a    [NCH];
    logic [DW-1:0]    rx_a    [NCH];
    logic [NCH-1:0]   en_v;
    logic [NCH-1:0]   eval_v;
    logic [NCH-1:0]   go_v;
    logic [2*NCH-1:0] dir_v;

    mspi_addr_dec #(.NCH(NCH), .AW(AW)) dec_i (
        .addr (bus_addr),
        .hit  (dec_hit),
        .chan (dec_chan),
        .rsel (dec_rsel)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = dec_hit && dec_chan == CW'(c);
        assign dir_v[2*c +: 2] = cfg_a[c][B_DIR_LO +: 2];

        mspi_chan #(.DW(DW)) ch_i (
            .clk          (clk),
            .rst          (rst),
            .wr_cfg       (bus_wr && sel && dec_rsel == RS_CFG),
            .wr_en        (bus_wr && sel && dec_rsel == RS_EN),
            .wr_tx        (bus_wr && sel && dec_rsel == RS_TX),
            .rd_rx        (bus_rd && sel && dec_rsel == RS_RX),
            .wdata        (bus_wdata),
            .xchg_inhibit (xchg_inhibit),
            .sx_rdata     (sx_rdata),
            .cfg          (cfg_a[c]),
            .flags        (flags_a[c]),
            .en           (en_v[c]),
            .tx           (tx_a[c]),
            .rx           (rx_a[c]),
            .eval_o       (eval_v[c]),
            .xchg_go      (go_v[c]),
            .tx_dreq      (tx_dreq[c]),
            .rx_dreq      (rx_dreq[c])
        );
    end

    always_comb begin
        sx_valid = 1'b0;
        sx_chan  = '0;
        sx_len   = '0;
        sx_wdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (go_v[c]) begin
                sx_valid = 1'b1;
                sx_chan  = CW'(c);
                sx_len   = f_len(cfg_a[c][B_WL_LO +: 5]);
                sx_wdata = tx_a[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= '0;
            if (dec_hit) begin
                case (dec_rsel)
                    RS_CFG:  bus_rdata <= DW'(cfg_a[dec_chan]);
                    RS_STAT: bus_rdata <= DW'(flags_a[dec_chan]);
                    RS_EN:   bus_rdata <= DW'(en_v[dec_chan]);
                    RS_TX:   bus_rdata <= tx_a[dec_chan];
                    RS_RX:   bus_rdata <= rx_a[dec_chan];
                    default: bus_rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/mspi_xfer_core_chk.sv
module mspi_xfer_core_chk #(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             sx_valid,
    input logic [NCH-1:0]   tx_dreq,
    input logic [NCH-1:0]   rx_dreq,
    input logic [NCH-1:0]   eval_v,
    input logic [NCH-1:0]   en_v,
    input logic [2*NCH-1:0] dir_v
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_dreq == '0 && rx_dreq == '0 && !sx_valid)); // R1

    AST_XCHG_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        sx_valid |-> $past(bus_wr || bus_rd)); // R13

    AST_EVAL_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (|eval_v) |-> $past(bus_wr || bus_rd)); // R13

    AST_SINGLE_EVAL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eval_v)); // R13

    AST_XCHG_NEEDS_EVAL: assert property (@(posedge clk) disable iff (rst)
        sx_valid |-> (|eval_v)); // R8

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_TXDREQ_MODE: assert property (@(posedge clk) disable iff (rst)
            tx_dreq[c] |-> (en_v[c] && dir_v[2*c +: 2] != 2'd1)); // R11
        AST_RXDREQ_MODE: assert property (@(posedge clk) disable iff (rst)
            rx_dreq[c] |-> (en_v[c] && dir_v[2*c +: 2] != 2'd2)); // R12
    end
endmodule

bind mspi_xfer_core mspi_xfer_core_chk #(.NCH(NCH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .sx_valid (sx_valid),
    .tx_dreq  (tx_dreq),
    .rx_dreq  (rx_dreq),
    .eval_v   (eval_v),
    .en_v     (en_v),
    .dir_v    (dir_v)
);

// File: tb/mspi_xfer_core_tb_top.sv
module mspi_xfer_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam logic [31:0] KEY = 32'h5A3C_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        xchg_inhibit = 1'b0;
    logic        sx_valid;
    logic [1:0]  sx_chan;
    logic [5:0]  sx_len;
    logic [31:0] sx_wdata;
    logic [31:0] sx_rdata;
    logic [3:0]  tx_dreq;
    logic [3:0]  rx_dreq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [22:0] m_cfg [NCH];
    logic        m_en  [NCH];
    logic        m_txe [NCH];
    logic        m_rxf [NCH];
    logic        m_eot [NCH];
    logic [31:0] m_tx  [NCH];
    logic [31:0] m_rx  [NCH];
    int          m_xcnt = 0;
    int          seen_xcnt = 0;
    int          exp_chan = 0;
    logic [31:0] exp_wdata = '0;
    logic [5:0]  exp_len = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sx_rdata = sx_wdata ^ KEY ^ {30'b0, sx_chan};

    mspi_xfer_core dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xchg_inhibit(xchg_inhibit), .sx_valid(sx_valid), .sx_chan(sx_chan),
        .sx_len(sx_len), .sx_wdata(sx_wdata), .sx_rdata(sx_rdata),
        .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && sx_valid) begin
            seen_xcnt++;
            chk(sx_chan == 2'(exp_chan), "R8 exchange channel", 32'(sx_chan), 32'(exp_chan));
            chk(sx_wdata == exp_wdata, "R8 exchange word", sx_wdata, exp_wdata);
            chk(sx_len == exp_len, "R8 exchange length", 32'(sx_len), 32'(exp_len));
        end
    end

    function automatic logic [7:0] adr(input int c, input int r);
        return 8'(44 + 20 * c + 4 * r);
    endfunction

    task automatic model_try(input int c);
        logic [1:0] dir;
        dir = m_cfg[c][13:12];
        if (!m_en[c]) return;
        if (m_rxf[c] && dir != 2'd2 && !m_cfg[c][19]) return;
        if (m_txe[c] && dir != 2'd1) return;
        if (!xchg_inhibit || m_cfg[c][20]) begin
            m_xcnt++;
            exp_chan  = c;
            exp_wdata = m_tx[c];
            exp_len   = {1'b0, m_cfg[c][11:7]} + 6'd1;
            m_rx[c]   = m_tx[c] ^ KEY ^ 32'(c);
        end
        m_tx[c]  = '0;
        m_eot[c] = 1'b1;
        m_txe[c] = 1'b1;
        if (dir != 2'd2) m_rxf[c] = 1'b1;
    endtask

    task automatic raw_wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic raw_rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic do_wr(input int c, input int r, input logic [31:0] d);
        case (r)
            0: m_cfg[c] = d[22:0];
            2: begin
                if (d[0] && !m_en[c]) begin m_en[c] = 1'b1; model_try(c); end
                else m_en[c] = d[0];
            end
            3: begin m_tx[c] = d; m_txe[c] = 1'b0; model_try(c); end
            default: ;
        endcase
        raw_wr(adr(c, r), d);
    endtask

    task automatic do_rd(input int c, input int r, output logic [31:0] d, output logic [31:0] e);
        case (r)
            0: e = 32'(m_cfg[c]);
            1: e = {29'b0, m_eot[c], m_txe[c], m_rxf[c]};
            2: e = 32'(m_en[c]);
            3: e = m_tx[c];
            default: begin e = m_rx[c]; m_rxf[c] = 1'b0; model_try(c); end
        endcase
        raw_rd(adr(c, r), d);
    endtask

    task automatic check_state(input int c, input string tag);
        logic [31:0] d, e;
        do_rd(c, 1, d, e);
        chk(d == e, {"R7 status ", tag}, d, e);
        for (int k = 0; k < NCH; k++) begin
            logic etx, erx;
            etx = m_en[k] && m_cfg[k][14] && m_txe[k] && m_cfg[k][13:12] != 2'd1;
            erx = m_en[k] && m_cfg[k][15] && m_rxf[k] && m_cfg[k][13:12] != 2'd2;
            chk(tx_dreq[k] == etx, {"R11 tx dreq ", tag}, 32'(tx_dreq[k]), 32'(etx));
            chk(rx_dreq[k] == erx, {"R12 rx dreq ", tag}, 32'(rx_dreq[k]), 32'(erx));
        end
        chk(seen_xcnt == m_xcnt, {"R13 exchange count ", tag}, 32'(seen_xcnt), 32'(m_xcnt));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, e;
        for (int c = 0; c < NCH; c++) begin
            m_cfg[c] = 23'h06_0000; m_en[c] = 0; m_txe[c] = 1; m_rxf[c] = 0;
            m_eot[c] = 0; m_tx[c] = '0; m_rx[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values, R2 address map
        for (int c = 0; c < NCH; c++) begin
            do_rd(c, 0, d, e); chk(d == 32'h0006_0000, "R1 setup reset", d, 32'h0006_0000);
            do_rd(c, 1, d, e); chk(d == 32'd2, "R1 status reset", d, 32'd2);
            do_rd(c, 2, d, e); chk(d == 32'd0, "R1 enable reset", d, 32'd0);
            do_rd(c, 3, d, e); chk(d == 32'd0, "R1 tx reset", d, 32'd0);
        end
        chk(tx_dreq == 4'd0 && rx_dreq == 4'd0, "R1 dreq reset", {24'b0, tx_dreq, rx_dreq}, 32'd0);
        raw_rd(8'h00, d); chk(d == 0, "R2 unmapped 0x00", d, 0);
        raw_rd(8'h28, d); chk(d == 0, "R2 unmapped 0x28", d, 0);
        raw_rd(8'h7C, d); chk(d == 0, "R2 unmapped 0x7C", d, 0);
        raw_rd(8'h2E, d); chk(d == 0, "R2 unaligned", d, 0);

        for (int c = 0; c < NCH; c++) begin
            for (int dir = 0; dir < 3; dir++) begin
                for (int v = 0; v < 8; v++) begin
                    logic [31:0] cfgw, pat;
                    int wl;
                    xchg_inhibit = v[2];
                    wl = 3 + ((c * 24 + dir * 8 + v) % 29);
                    cfgw = 32'hFF80_0000 | (32'(v[1]) << 20) | (32'(v[0]) << 19) |
                           (32'h3 << 14) | (32'(dir) << 12) | (32'(wl) << 7) | 32'h55;
                    pat = 32'hC0DE_0000 + 32'(c << 12) + 32'(dir << 8) + 32'(v << 4);

                    do_wr(c, 2, 32'd0);
                    do_wr(c, 0, cfgw);
                    do_rd(c, 0, d, e);
                    chk(d == {9'b0, cfgw[22:0]}, "R3 setup mask", d, {9'b0, cfgw[22:0]});
                    do_wr(c, 3, pat + 1);
                    check_state(c, "R5 R10 tx while disabled");
                    do_wr(c, 2, 32'd1);
                    check_state(c, "R10 enable rise");
                    do_wr(c, 2, 32'd1);
                    check_state(c, "R10 enable repeat");
                    do_rd(c, 4, d, e);
                    chk(d == e, "R9 R8 rx word", d, e);
                    check_state(c, "R9 after rx read");
                    do_wr(c, 3, pat + 2);
                    check_state(c, "R5 tx write");
                    do_wr(c, 3, pat + 3);
                    check_state(c, "R6 tx second");
                    do_rd(c, 3, d, e);
                    chk(d == e, "R7 tx word", d, e);
                    do_rd(c, 4, d, e);
                    chk(d == e, "R9 rx word again", d, e);
                    check_state(c, "R9 second read");
                    do_wr(c, 1, 32'hFFFF_FFFF);
                    do_wr(c, 4, 32'h1234_5678);
                    check_state(c, "R4 read-only writes");
                    do_rd(c, 4, d, e);
                    chk(d == e, "R4 rx unchanged", d, e);
                    check_state(c, "R4 final");
                end
            end
            do_wr(c, 2, 32'd0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule